// File: doc/BRIEF.md
# Packed Sign-Bit Test Flag Unit

This unit evaluates a packed sign-bit test between two vector operands and produces the resulting status flags. For every lane it looks only at the lane's most significant bit, in two products: the AND of the two sources, and the AND of the inverted first source with the second. ZF reports that no lane sign bit survives the first product. CF reports the same for the second product. Every other bit of the incoming flags word is either cleared (the remaining arithmetic status bits) or passed through unchanged.

A small decode stage turns the opcode byte, the operand-width bit W and the vector-length bit into lane size, operand length and an undefined-opcode indication. Operations enter through a valid/ready handshake. The result sits in a single output register until it is taken downstream, and that register can be reloaded in the same cycle it drains.

Top module: `packed_sign_test`

## Requirements
- R1: ZF (flags bit 6) of a defined operation is 1 exactly when no tested sign bit of (src_a AND src_b) is set.
- R2: CF (flags bit 0) of a defined operation is 1 exactly when no tested sign bit of (NOT src_a AND src_b) is set.
- R3: In 32-bit lane mode the tested positions are bits 31 and 63 of every 64-bit chunk. For example, 256-bit operands with src_b all ones and src_a holding 0x7fffffff in every 32-bit lane give ZF=1 and CF=0.
- R4: In 64-bit lane mode only bit 63 of every 64-bit chunk is tested, and bit 31 has no effect.
- R5: vec_len=0 selects 128 bits (chunks 0 and 1) and vec_len=1 selects 256 bits (chunks 0 to 3). With vec_len=0, bits 255:128 of both sources have no effect.
- R6: A defined operation clears OF (bit 11), SF (bit 7), AF (bit 4) and PF (bit 2). Every flag bit other than these six status bits is copied from flags_in.
- R7: Opcode 0x0E selects 32-bit lanes and opcode 0x0F selects 64-bit lanes.
- R8: An operation with w_bit=1 produces undef_op=1 and flags_out equal to flags_in.
- R9: An opcode other than 0x0E or 0x0F produces undef_op=1 and flags_out equal to flags_in.
- R10: in_ready is 1 exactly when the output register is empty or out_ready is 1. An accepted operation appears on the outputs with out_valid=1 in the following cycle.
- R11: While out_valid=1 and out_ready=0, out_valid, flags_out and undef_op hold their values.
- R12: After reset, out_valid=0, flags_out=0 and undef_op=0.
- R13: All-zero operands give ZF=1 and CF=1. All-ones operands give ZF=0 and CF=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| opcode | input | 8 | Opcode byte: 0x0E for 32-bit lanes, 0x0F for 64-bit lanes |
| w_bit | input | 1 | Operand-width bit; 1 is an undefined encoding |
| vec_len | input | 1 | 0 selects 128 bits, 1 selects 256 bits |
| src_a | input | 256 | First source |
| src_b | input | 256 | Second source |
| flags_in | input | 32 | Current flags word |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Downstream takes the result |
| flags_out | output | 32 | Updated flags word |
| undef_op | output | 1 | Encoding was undefined; flags_out is flags_in unchanged |

## Verification
The bench builds the block with its default parameters: a 256-bit maximum vector, 64-bit chunks and a 32-bit flags word. These defaults give both lane sizes and both vector lengths, so the bench can separate bit-31 from bit-63 effects and detect leakage from the upper half in 128-bit mode. A behavioural model, driven with the same stimulus and random backpressure, is compared against the outputs on every clock. The stimulus includes stalls longer than one cycle and back-to-back transfers in which the register drains and reloads in the same cycle.

// File: rtl/packed_sign_test.sv
module packed_sign_test #(
  parameter int         VEC_MAX    = 256,
  parameter int         CHUNK_W    = 64,
  parameter int         FLAG_W     = 32,
  parameter logic [7:0] OPC_NARROW = 8'h0E,
  parameter logic [7:0] OPC_WIDE   = 8'h0F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         opcode,
  input  logic               w_bit,
  input  logic               vec_len,
  input  logic [VEC_MAX-1:0] src_a,
  input  logic [VEC_MAX-1:0] src_b,
  input  logic [FLAG_W-1:0]  flags_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FLAG_W-1:0]  flags_out,
  output logic               undef_op
);
  localparam int CHUNKS     = VEC_MAX / CHUNK_W;
  localparam int LOW_CHUNKS = CHUNKS / 2;
  localparam int HALF_W     = CHUNK_W / 2;
  localparam int BIT_C = 0, BIT_P = 2, BIT_A = 4, BIT_Z = 6, BIT_S = 7, BIT_O = 11;
  localparam logic [FLAG_W-1:0] STATUS_MASK =
    FLAG_W'((1 << BIT_C) | (1 << BIT_P) | (1 << BIT_A) | (1 << BIT_Z) | (1 << BIT_S) | (1 << BIT_O));

  logic lane32, known_op, bad_enc;
  assign lane32   = (opcode == OPC_NARROW);
  assign known_op = (opcode == OPC_NARROW) || (opcode == OPC_WIDE);
  assign bad_enc  = w_bit || !known_op;

  logic [CHUNKS-1:0] hit_and, hit_andn;

  for (genvar c = 0; c < CHUNKS; c++) begin : g_chunk
    logic               active;
    logic [CHUNK_W-1:0] msk, a_c, b_c;
    assign active = (c < LOW_CHUNKS) || vec_len;
    assign msk = {1'b1, {(HALF_W-1){1'b0}}, lane32, {(HALF_W-1){1'b0}}} & {CHUNK_W{active}};
    assign a_c = src_a[c*CHUNK_W +: CHUNK_W];
    assign b_c = src_b[c*CHUNK_W +: CHUNK_W];
    assign hit_and[c]  = |(a_c & b_c & msk);
    assign hit_andn[c] = |(~a_c & b_c & msk);
  end

  logic [FLAG_W-1:0] next_flags;
  always_comb begin
    next_flags = flags_in;
    if (!bad_enc) begin
      next_flags        = flags_in & ~STATUS_MASK;
      next_flags[BIT_Z] = ~|hit_and;
      next_flags[BIT_C] = ~|hit_andn;
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flags_out <= '0;
      undef_op  <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        out_valid <= 1'b1;
        flags_out <= next_flags;
        undef_op  <= bad_enc;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module packed_sign_test_chk #(
  parameter int VEC_MAX = 256,
  parameter int FLAG_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [7:0]         opcode,
  input logic               w_bit,
  input logic               vec_len,
  input logic [VEC_MAX-1:0] src_a,
  input logic [VEC_MAX-1:0] src_b,
  input logic [FLAG_W-1:0]  flags_in,
  input logic               out_valid,
  input logic               out_ready,
  input logic [FLAG_W-1:0]  flags_out,
  input logic               undef_op
);
  logic take, good;
  assign take = in_valid && in_ready;
  assign good = !w_bit && (opcode == 8'h0E || opcode == 8'h0F);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(flags_out) && $stable(undef_op));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  assert_wbit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && w_bit |=> undef_op && flags_out == $past(flags_in));

  assert_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take && good |=> !undef_op && !flags_out[11] && !flags_out[7] && !flags_out[4] && !flags_out[2]
                     && flags_out[FLAG_W-1:12] == $past(flags_in[FLAG_W-1:12])
                     && flags_out[10:8] == $past(flags_in[10:8]));

  assert_zero_src_R13: assert property (@(posedge clk) disable iff (!rst_n)
    take && good && src_b == '0 |=> flags_out[6] && flags_out[0]);
endmodule

bind packed_sign_test packed_sign_test_chk #(.VEC_MAX(VEC_MAX), .FLAG_W(FLAG_W)) u_chk (.*);

// File: tb/tb_packed_sign_test.sv
module tb_packed_sign_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0;
  logic         in_valid = 0, in_ready, w_bit = 0, vec_len = 0, out_valid, out_ready = 0, undef_op;
  logic [7:0]   opcode = 8'h0E;
  logic [255:0] src_a = '0, src_b = '0;
  logic [31:0]  flags_in = '0, flags_out;

  int errors = 0, checks = 0;
  string cur_tag = "R10";

  logic        m_valid = 0, m_undef = 0;
  logic [31:0] m_flags = '0;

  packed_sign_test dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] ref_op(logic [7:0] opc, logic w, logic len,
                                         logic [255:0] a, logic [255:0] b, logic [31:0] fin);
    int lane = (opc == 8'h0E) ? 32 : 64;
    int nbits = len ? 256 : 128;
    logic zf = 1, cf = 1;
    logic [31:0] f;
    if (w || (opc != 8'h0E && opc != 8'h0F)) return {1'b1, fin};
    for (int i = lane - 1; i < nbits; i += lane) begin
      if (a[i] && b[i]) zf = 0;
      if (!a[i] && b[i]) cf = 0;
    end
    f = fin;
    f[0] = cf; f[2] = 0; f[4] = 0; f[6] = zf; f[7] = 0; f[11] = 0;
    return {1'b0, f};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic step(logic v, logic [7:0] opc, logic w, logic len,
                      logic [255:0] a, logic [255:0] b, logic [31:0] fin, logic rdy);
    logic [32:0] r;
    logic acc;
    chk({cur_tag, " out_valid"}, 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      chk({cur_tag, " flags_out"}, 64'(flags_out), 64'(m_flags));
      chk({cur_tag, " undef_op"}, 64'(undef_op), 64'(m_undef));
    end
    in_valid = v; opcode = opc; w_bit = w; vec_len = len;
    src_a = a; src_b = b; flags_in = fin; out_ready = rdy;
    #1;
    acc = !m_valid || rdy;
    chk("R10 in_ready", 64'(in_ready), 64'(acc));
    if (m_valid && rdy) m_valid = 0;
    if (v && acc) begin
      r = ref_op(opc, w, len, a, b, fin);
      m_valid = 1; m_undef = r[32]; m_flags = r[31:0];
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(string tag, logic [7:0] opc, logic w, logic len,
                    logic [255:0] a, logic [255:0] b, logic [31:0] fin);
    cur_tag = tag;
    step(1, opc, w, len, a, b, fin, 1);
    step(0, opc, 0, 0, '0, '0, '0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [255:0] sgn_clear;
    for (int i = 0; i < 8; i++) sgn_clear[i*32 +: 32] = 32'h7fffffff;
    #(CLK_PERIOD * 2 + 2);
    chk("R12 out_valid", 64'(out_valid), 0);
    chk("R12 flags_out", 64'(flags_out), 0);
    chk("R12 undef_op", 64'(undef_op), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    op("R13 zeros", 8'h0E, 0, 1, '0, '0, 32'hffff_ffff);
    op("R13 ones", 8'h0E, 0, 1, '1, '1, 32'h0000_0000);
    op("R13 ones 64", 8'h0F, 0, 0, '1, '1, 32'h1234_5678);
    op("R3 256 sign-clear", 8'h0E, 0, 1, sgn_clear, '1, 32'hdead_beef);
    op("R4 bit31 ignored", 8'h0F, 0, 1, {4{64'h0000_0000_8000_0000}}, '1, 32'h0);
    op("R7 bit31 counts", 8'h0E, 0, 1, {4{64'h0000_0000_8000_0000}}, '1, 32'h0);
    op("R1 one lane AND", 8'h0F, 0, 1, {64'h8000_0000_0000_0000, 192'h0}, {64'h8000_0000_0000_0000, 192'h0}, 32'h0);
    op("R2 one lane ANDN", 8'h0F, 0, 1, '0, {192'h0, 64'h8000_0000_0000_0000}, 32'h0);
    op("R5 upper ignored", 8'h0E, 0, 0, {128'h0, 128'h0} | {{128{1'b1}}, 128'h0}, {{128{1'b1}}, 128'h0}, 32'h5555_5555);
    op("R5 upper used", 8'h0E, 0, 1, {{128{1'b1}}, 128'h0}, {{128{1'b1}}, 128'h0}, 32'h5555_5555);
    op("R6 passthrough", 8'h0E, 0, 0, rnd256(), rnd256(), 32'hffff_ffff);
    op("R8 W set", 8'h0E, 1, 1, '0, '0, 32'hcafe_f00d);
    op("R9 bad opcode", 8'h10, 0, 1, '0, '0, 32'h0bad_0bad);

    cur_tag = "R11 stall";
    step(1, 8'h0F, 0, 1, '0, '0, 32'h0000_0f00, 0);
    step(1, 8'h0E, 0, 1, '1, '1, 32'h0, 0);
    step(1, 8'h0E, 0, 1, '1, '1, 32'h0, 0);
    step(1, 8'h0E, 0, 1, '1, '1, 32'h0, 1);
    step(1, 8'h0F, 0, 0, '1, '0, 32'h7, 1);
    step(0, 8'h0F, 0, 0, '0, '0, 32'h0, 1);

    cur_tag = "R10 random";
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] opc = ($urandom % 16 == 0) ? 8'h20 : (($urandom % 2) ? 8'h0E : 8'h0F);
      logic [255:0] a = rnd256() & rnd256();
      logic [255:0] b = rnd256() & rnd256() & rnd256();
      if (n % 5 == 0) a = '0;
      step(($urandom % 10) < 7, opc, ($urandom % 20) == 0, $urandom % 2,
           a, b, $urandom, ($urandom % 10) < 6);
    end
    step(0, 8'h0E, 0, 0, '0, '0, '0, 1);
    step(0, 8'h0E, 0, 0, '0, '0, '0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule